// File: doc/BRIEF.md
# Multiprocessor Interrupt Router with Level Encoding

This block gathers 32 system interrupt lines into a master pending word. Each line is mapped to a processor priority level through a fixed sparse table. The block then presents one external-interrupt request, carrying the highest enabled level, to a processor chosen by software. A master disable word masks individual lines and also holds one global kill bit. Each processor also owns a pending word with two views for software: one that sets bits and one that clears them. When a line changes, the level bit it maps to is set in, or cleared from, the pending word of the processor that is currently the target.

Software reaches everything through one word-wide register port. Address bit 7 selects the master window; otherwise address bits [5:4] select a processor window. Each processor has a single request/index pair. The request stays raised until that processor returns a one-cycle acknowledge. A new request is issued only when no earlier one is outstanding, so a later interrupt waits in the pending words until the acknowledge causes a fresh evaluation.

Top module: `mpic_top`

## Requirements
- R1: After reset every pending word reads 0, the master disable word reads 0xFFFFFFFF, the target reads 0 and no request is raised.
- R2: A write to byte offset 0x4 of processor window c (byte address c*0x10+0x4) clears, in that processor's pending word, the bits of (data & 0xFFFE0000).
- R3: A write to byte offset 0x8 of processor window c ORs (data & 0xFFFE0000) into that processor's pending word, so bits 16..0 of the data have no effect. The pending word reads at offset 0x0.
- R4: In the master window (base 0x80), a write to 0x88 clears the disable bits of (data & ~0x7FB2007F). Disable bits set in 0x7FB2007F always stay 1. The disable word reads at 0x84.
- R5: A write to 0x8C sets the disable bits of (data & ~0x7FB2007F) and clears the same bits of the master pending word, which reads at 0x80.
- R6: A write to 0x90 sets the target processor to data modulo 4, and 0x90 reads it back.
- R7: When line n rises, master pending bit n is set and bit level(n) of the current target's pending word is set. When line n falls, both bits are cleared. The new values are readable one cycle after the change.
- R8: level(n) is 6, 4, 10, 8, 11 and 15 for lines 16, 18, 19, 20, 22 and 28, and 0 for every other line.
- R9: An evaluation is triggered by a line change, a write to 0x88 or an acknowledge. Two cycles after the trigger, if (master pending & ~disable) is nonzero, disable bit 31 is 0 and the target has no request outstanding, the target raises its request with index 0x10 | (highest level among those active bits).
- R10: While disable bit 31 is 1, no request is raised.
- R11: A raised request and its index hold until the processor's acknowledge. The request drops in the following cycle, and the resulting evaluation can raise a new request one cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_lines | input | 32 | System interrupt lines, level sensitive |
| cpu_ack | input | 4 | Per-processor acknowledge pulse |
| cpu_req | output | 4 | Per-processor interrupt request |
| cpu_index | output | 32 | Per-processor 8-bit index, processor c in bits [8c+7:8c] |

## Verification
Register and pending-word results appear on the read port after the first clock edge following a write or a line change. A request appears after the second edge, because the trigger is registered first and the evaluation result is registered next. After an acknowledge, the request is low after the first edge and a re-issued request is present after the second. The bench drives inputs just after a falling edge and counts rising edges to these points before it samples. All 32 lines are swept one at a time against the level table.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
   localparam int SRC_N     = 32;
   localparam int WORD_W    = 32;
   localparam int LVL_W     = 4;
   localparam int IDX_W     = 8;
   localparam logic [WORD_W-1:0] DIS_LOCK = 32'h7FB2007F;
   localparam logic [WORD_W-1:0] SW_MASK  = 32'hFFFE0000;
   localparam logic [IDX_W-LVL_W-1:0] EXT_TRAP = 4'h1;
   localparam int GLOBAL_BIT = 31;

   typedef enum logic [2:0] {
      M_PEND   = 3'd0,
      M_DIS    = 3'd1,
      M_ENABLE = 3'd2,
      M_MASK   = 3'd3,
      M_TARGET = 3'd4
   } mreg_e;

   typedef enum logic [1:0] {
      C_PEND  = 2'd0,
      C_CLEAR = 2'd1,
      C_SET   = 2'd2,
      C_NONE  = 2'd3
   } creg_e;

   function automatic logic [LVL_W-1:0] src_level(input int n);
      case (n)
         16:      return 4'd6;
         18:      return 4'd4;
         19:      return 4'd10;
         20:      return 4'd8;
         22:      return 4'd11;
         28:      return 4'd15;
         default: return 4'd0;
      endcase
   endfunction
endpackage

// File: rtl/mpic_lvl_enc.sv
module mpic_lvl_enc
   import mpic_pkg::*;
#(
   parameter int N = SRC_N
) (
   input  logic [N-1:0]     active,
   output logic             any,
   output logic [LVL_W-1:0] level
);
   logic [LVL_W-1:0] lvl_tab [N];

   for (genvar g = 0; g < N; g++) begin : g_tab
      assign lvl_tab[g] = src_level(g);
   end

   always_comb begin
      level = '0;
      for (int i = 0; i < N; i++) begin
         if (active[i] && (lvl_tab[i] > level)) level = lvl_tab[i];
      end
   end

   assign any = |active;
endmodule

// File: rtl/mpic_cpu_slot.sv
module mpic_cpu_slot
   import mpic_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] sw_clr,
   input  logic [WORD_W-1:0] sw_set,
   input  logic [WORD_W-1:0] hw_clr,
   input  logic [WORD_W-1:0] hw_set,
   input  logic              fire,
   input  logic [LVL_W-1:0]  fire_lvl,
   input  logic              ack,
   output logic [WORD_W-1:0] pend,
   output logic              req,
   output logic [IDX_W-1:0]  idx
);
   logic [WORD_W-1:0] pend_q;
   logic              req_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         req_q  <= 1'b0;
         idx_q  <= '0;
      end else begin
         pend_q <= ((pend_q & ~sw_clr & ~hw_clr) | sw_set | hw_set);
         if (ack) begin
            req_q <= 1'b0;
            idx_q <= '0;
         end else if (fire && !req_q) begin
            req_q <= 1'b1;
            idx_q <= {EXT_TRAP, fire_lvl};
         end
      end
   end

   assign pend = pend_q;
   assign req  = req_q;
   assign idx  = idx_q;
endmodule

// File: rtl/mpic_top.sv
module mpic_top
   import mpic_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   parameter int ADDR_W   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [WORD_W-1:0]         reg_wdata,
   output logic [WORD_W-1:0]         reg_rdata,
   input  logic [SRC_N-1:0]          src_lines,
   input  logic [NUM_CPUS-1:0]       cpu_ack,
   output logic [NUM_CPUS-1:0]       cpu_req,
   output logic [NUM_CPUS*IDX_W-1:0] cpu_index
);
   localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

   initial begin
      assert (NUM_CPUS >= 2 && (NUM_CPUS & (NUM_CPUS - 1)) == 0)
         else $fatal(1, "NUM_CPUS must be a power of two of at least 2");
      assert (ADDR_W >= 5 + CPU_W)
         else $fatal(1, "ADDR_W too narrow for the processor windows");
   end

   // address decode
   logic             is_master;
   logic [2:0]       m_sel;
   logic [1:0]       c_reg;
   logic [CPU_W-1:0] c_sel;
   logic             wr_m, wr_c, en_wr, mask_wr, tgt_wr;
   logic [WORD_W-1:0] filt;

   assign is_master = reg_addr[ADDR_W-1];
   assign m_sel     = reg_addr[4:2];
   assign c_reg     = reg_addr[3:2];
   assign c_sel     = reg_addr[4 +: CPU_W];
   assign wr_m      = reg_wr && is_master;
   assign wr_c      = reg_wr && !is_master;
   assign en_wr     = wr_m && (m_sel == M_ENABLE);
   assign mask_wr   = wr_m && (m_sel == M_MASK);
   assign tgt_wr    = wr_m && (m_sel == M_TARGET);
   assign filt      = reg_wdata & ~DIS_LOCK;

   // master state
   logic [SRC_N-1:0]  src_q;
   logic [WORD_W-1:0] dis_q;
   logic [WORD_W-1:0] mpend_q;
   logic [CPU_W-1:0]  tgt_q;
   logic              eval_q;
   logic [SRC_N-1:0]  rise, fall;

   assign rise = src_lines & ~src_q;
   assign fall = ~src_lines & src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q   <= '0;
         dis_q   <= '1;
         mpend_q <= '0;
         tgt_q   <= '0;
         eval_q  <= 1'b0;
      end else begin
         src_q <= src_lines;
         if (en_wr)        dis_q <= dis_q & ~filt;
         else if (mask_wr) dis_q <= dis_q | filt;
         mpend_q <= ((mpend_q & ~fall) | rise) & ~(mask_wr ? filt : '0);
         if (tgt_wr) tgt_q <= reg_wdata[CPU_W-1:0];
         eval_q <= (|rise) || (|fall) || en_wr || (|cpu_ack);
      end
   end

   // level bits for the target processor
   logic [WORD_W-1:0] rise_lvl, fall_lvl;

   always_comb begin
      rise_lvl = '0;
      fall_lvl = '0;
      for (int n = 0; n < SRC_N; n++) begin
         if (rise[n]) rise_lvl[src_level(n)] = 1'b1;
         if (fall[n]) fall_lvl[src_level(n)] = 1'b1;
      end
   end

   // evaluation
   logic             act_any;
   logic [LVL_W-1:0] act_lvl;
   logic             fire_ok;

   mpic_lvl_enc #(.N(SRC_N)) enc_i (
      .active (mpend_q & ~dis_q),
      .any    (act_any),
      .level  (act_lvl)
   );

   assign fire_ok = eval_q && act_any && !dis_q[GLOBAL_BIT];

   // per-processor slots
   logic [WORD_W-1:0] cpend [NUM_CPUS];

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic here, win;
      assign here = (tgt_q == CPU_W'(c));
      assign win  = wr_c && (c_sel == CPU_W'(c));

      mpic_cpu_slot slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .sw_clr   ((win && c_reg == C_CLEAR) ? (reg_wdata & SW_MASK) : '0),
         .sw_set   ((win && c_reg == C_SET)   ? (reg_wdata & SW_MASK) : '0),
         .hw_clr   (here ? fall_lvl : '0),
         .hw_set   (here ? rise_lvl : '0),
         .fire     (fire_ok && here),
         .fire_lvl (act_lvl),
         .ack      (cpu_ack[c]),
         .pend     (cpend[c]),
         .req      (cpu_req[c]),
         .idx      (cpu_index[c*IDX_W +: IDX_W])
      );
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (is_master) begin
         case (m_sel)
            M_PEND:   reg_rdata = mpend_q;
            M_DIS:    reg_rdata = dis_q;
            M_TARGET: reg_rdata = WORD_W'(tgt_q);
            default:  reg_rdata = '0;
         endcase
      end else if (c_reg == C_PEND) begin
         reg_rdata = cpend[c_sel];
      end
   end
endmodule

// File: rtl/mpic_chk.sv
module mpic_chk
   import mpic_pkg::*;
#(
   parameter int NUM_CPUS = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_CPUS-1:0]       cpu_req,
   input logic [NUM_CPUS*IDX_W-1:0] cpu_index,
   input logic [NUM_CPUS-1:0]       cpu_ack,
   input logic [WORD_W-1:0]         dis_q,
   input logic [WORD_W-1:0]         mpend_q
);
   assert_lock_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_q & DIS_LOCK) == DIS_LOCK);

   assert_one_new_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cpu_req & ~$past(cpu_req)));

   for (genvar i = 0; i < NUM_CPUS; i++) begin : g_c
      assert_trap_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cpu_req[i]) |-> cpu_index[i*IDX_W+LVL_W +: IDX_W-LVL_W] == EXT_TRAP);

      assert_req_needs_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cpu_req[i]) |-> $past(|(mpend_q & ~dis_q)));

      assert_global_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cpu_req[i]) |-> !$past(dis_q[GLOBAL_BIT]));

      assert_ack_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_ack[i] && cpu_req[i]) |=> !cpu_req[i]);

      assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_req[i] && !cpu_ack[i]) |=>
            (cpu_req[i] && $stable(cpu_index[i*IDX_W +: IDX_W])));
   end
endmodule

bind mpic_top mpic_chk #(.NUM_CPUS(NUM_CPUS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_index (cpu_index),
   .cpu_ack   (cpu_ack),
   .dis_q     (dis_q),
   .mpend_q   (mpend_q)
);

// File: tb/mpic_top_tb_top.sv
`timescale 1ns/1ps
module mpic_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] src_lines = '0;
   logic [3:0]  cpu_ack = '0;
   logic [3:0]  cpu_req;
   logic [31:0] cpu_index;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mpic_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_lines(src_lines),
      .cpu_ack(cpu_ack), .cpu_req(cpu_req), .cpu_index(cpu_index)
   );

   function automatic int lvl(input int n);
      case (n)
         16: return 6;   18: return 4;  19: return 10;
         20: return 8;   22: return 11; 28: return 15;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick(1);
      reg_wr = 1'b0;
   endtask

   task automatic ack(input int c);
      cpu_ack[c] = 1'b1;
      tick(1);
      cpu_ack = '0;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      rd(8'h80, d); chk("R1 master pending", d, 32'h0);
      rd(8'h84, d); chk("R1 disable", d, 32'hFFFFFFFF);
      rd(8'h90, d); chk("R1 target", d, 32'h0);
      for (int c = 0; c < 4; c++) begin
         rd(8'(c * 16), d); chk("R1 cpu pending", d, 32'h0);
      end
      chk("R1 no request", {28'h0, cpu_req}, 32'h0);

      // R7 / R8 sweep of every line against the level table
      for (int n = 0; n < 32; n++) begin
         src_lines = 32'h1 << n;
         tick(1);
         rd(8'h80, d); chk("R7 rise master bit", d, 32'h1 << n);
         rd(8'h00, d); chk("R8 level bit", d, 32'h1 << lvl(n));
         src_lines = '0;
         tick(1);
         rd(8'h80, d); chk("R7 fall master bit", d, 32'h0);
         rd(8'h00, d); chk("R7 fall level bit", d, 32'h0);
         tick(1);
         chk("R10 all disabled no request", {28'h0, cpu_req}, 32'h0);
      end

      // R4 enable filtered
      wr(8'h88, 32'h004D0000);
      rd(8'h84, d); chk("R4 enable lines", d, 32'hFFB2FFFF);
      wr(8'h88, 32'h7FB2007F);
      rd(8'h84, d); chk("R4 locked bits stay", d, 32'hFFB2FFFF);

      // R10 global disable holds off
      src_lines[19] = 1'b1;
      tick(3);
      chk("R10 global disable", {28'h0, cpu_req}, 32'h0);

      // R9 clear global bit -> request two cycles later
      wr(8'h88, 32'h80000000);
      chk("R9 not yet after one edge", {28'h0, cpu_req}, 32'h0);
      tick(1);
      chk("R9 request cpu0", {28'h0, cpu_req}, 32'h1);
      chk("R9 index level 10", {24'h0, cpu_index[7:0]}, 32'h1A);

      // R11 held while outstanding
      src_lines[22] = 1'b1;
      tick(3);
      chk("R11 index held", {24'h0, cpu_index[7:0]}, 32'h1A);
      ack(0);
      chk("R11 request dropped", {28'h0, cpu_req}, 32'h0);
      tick(1);
      chk("R11 reissued level 11", {24'h0, cpu_index[7:0]}, 32'h1B);
      chk("R11 reissued request", {28'h0, cpu_req}, 32'h1);

      // R6 target modulo
      wr(8'h90, 32'd6);
      rd(8'h90, d); chk("R6 target modulo", d, 32'd2);
      ack(0);
      tick(1);
      chk("R6 request to cpu2", {28'h0, cpu_req}, 32'h4);
      chk("R9 cpu2 index", {24'h0, cpu_index[23:16]}, 32'h1B);

      // R5 mask clears pending
      wr(8'h8C, 32'h00400000);
      rd(8'h80, d); chk("R5 pending cleared", d, 32'h00080000);
      rd(8'h84, d); chk("R5 disable set", d, 32'h7FF2FFFF);

      // R7 level bit goes to current target
      src_lines[16] = 1'b1;
      tick(1);
      rd(8'h20, d); chk("R7 target cpu2 level 6", d, 32'h40);
      rd(8'h00, d); chk("R7 cpu0 untouched", d, 32'h00000C00);

      // R2 / R3 software views
      wr(8'h18, 32'hFFFFFFFF);
      rd(8'h10, d); chk("R3 set filtered", d, 32'hFFFE0000);
      wr(8'h14, 32'h00FF0001);
      rd(8'h10, d); chk("R2 clear filtered", d, 32'hFF000000);
      wr(8'h18, 32'h0001FFFF);
      rd(8'h10, d); chk("R3 low bits ignored", d, 32'hFF000000);
      wr(8'h04, 32'hFFFFFFFF);
      rd(8'h00, d); chk("R2 low level bits kept", d, 32'h00000C00);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule